// File: doc/BRIEF.md
# DMA Copy Engine with Snapshotted Region Guard

This block copies a run of words from a source address range to a destination address range over a single memory port. Software starts a request with one write to the control port, which carries the source address, the destination address and the word count. Before any memory access is made, the engine checks both address ranges against a small fixed set of protection regions. The source range needs read permission and the destination range needs write permission. If either check fails, the request is aborted and a fault is raised.

The region addresses and permission settings come in on input ports. They are copied into internal registers at the moment a request is accepted. Every permission decision for that request uses only these copies. Any change on the live protection inputs after the request starts has no effect until the engine is idle or done again. As a result, a region cannot be swapped between the check and the use. Completion and fault are both held as status levels until the requester acknowledges them with another control write.

Top module: `dmap_top`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `done_o`, `fault_o` and `mem_req_o` are all low.
- R2: A control write (`ctl_we_i` high for one cycle) while idle accepts the request. The source, destination and word count are taken from `ctl_src_i`, `ctl_dst_i` and `ctl_len_i`. `busy_o` is high on the following cycle.
- R3: Each region's settings are 5 bits. Bit 0 grants read, bit 1 grants write and bit 2 is execute, which this engine ignores. Bits 4:3 select the match mode: 00 off, 01 exact (only the region address itself), 10 power-of-two aligned, 11 off.
- R4: In power-of-two mode, let t be the number of trailing ones in the region address. The region then covers 2^(t+1) addresses, starting at the region address with its low t+1 bits cleared.
- R5: A request passes only if one region with read permission contains both the first and last source address, and one region with write permission contains both the first and last destination address. Otherwise the engine raises `fault_o` and makes no memory access.
- R6: The region settings are captured from the input ports only by a control write while idle or done. Changes on those inputs during checking or copying are ignored. This holds even when the new value would admit an address that the captured value rejects.
- R7: A request whose captured settings have every region off ends in a fault.
- R8: Each word is copied as a read of the current source address followed by a write of the read data to the current destination address. Both addresses then advance by one.
- R9: While `mem_req_o` is high and `mem_ready_i` is low, the request, address, direction and write data hold their values.
- R10: A word count of zero ends in `done_o` without any memory access or permission check.
- R11: `done_o` or `fault_o` stays high until a control write acknowledges it, after which the engine is idle. Control writes during checking or copying are ignored.
- R12: A range whose last address would wrap past the top of the address space fails the check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control write strobe: starts a request when idle, acknowledges status when done or aborted |
| ctl_src_i | input | AW | Source start address |
| ctl_dst_i | input | AW | Destination start address |
| ctl_len_i | input | LW | Number of words to copy |
| prot_addr_i | input | NRGN*AW | Region addresses, region 0 in the low bits |
| prot_cfg_i | input | NRGN*5 | Region settings, region 0 in the low bits |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write when high, a read when low |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid in the cycle a read is accepted |
| mem_ready_i | input | 1 | Memory accepts the current access this cycle |
| busy_o | output | 1 | Request is being checked or copied |
| done_o | output | 1 | Request completed, held until acknowledged |
| fault_o | output | 1 | Request rejected by the region check, held until acknowledged |

## Verification
The bound checker watches a few properties on every cycle. It confirms that the captured region settings never move while a request is in flight. It confirms that a stalled access holds still, that a fault can only follow the checking step, and that status levels persist until acknowledged. What only the bench scenarios can show is whether each decision was correct. That covers region arithmetic (power-of-two spans, exact matches, range ends, wrap-around), the read-then-write data order, and the attempt to widen a region in the middle of a request being refused.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_XFER  = 3'd2,
    ST_DONE  = 3'd3,
    ST_ABORT = 3'd4
  } dmap_state_e;

  typedef enum logic [1:0] {
    MM_OFF   = 2'b00,
    MM_EXACT = 2'b01,
    MM_POW2  = 2'b10,
    MM_RSVD  = 2'b11
  } dmap_match_e;

  localparam int RCFG_W   = 5;
  localparam int RCFG_RD  = 0;
  localparam int RCFG_WR  = 1;
  localparam int RCFG_EX  = 2;
  localparam int RCFG_MLO = 3;

endpackage

// File: rtl/dmap_prot_regs.sv
module dmap_prot_regs
  import dmap_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NRGN = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_en,
  input  logic [NRGN*AW-1:0]     addr_i,
  input  logic [NRGN*RCFG_W-1:0] cfg_i,
  output logic [NRGN*AW-1:0]     addr_q,
  output logic [NRGN*RCFG_W-1:0] cfg_q
);

  // Reset value: every region off, which denies every access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cfg_q  <= '0;
    end else if (cap_en) begin
      addr_q <= addr_i;
      cfg_q  <= cfg_i;
    end
  end

endmodule

// File: rtl/dmap_prot_check.sv
module dmap_prot_check
  import dmap_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NRGN = 2
) (
  input  logic [AW-1:0]          lo_i,
  input  logic [AW-1:0]          hi_i,
  input  logic                   wrap_i,
  input  logic                   need_rd_i,
  input  logic                   need_wr_i,
  input  logic [NRGN*AW-1:0]     rgn_addr_i,
  input  logic [NRGN*RCFG_W-1:0] rgn_cfg_i,
  output logic                   allow_o
);

  logic [NRGN-1:0] rgn_ok;

  for (genvar g = 0; g < NRGN; g++) begin : g_rgn
    logic [AW-1:0]     base;
    logic [AW-1:0]     base_inc;
    logic [AW-1:0]     span_mask;
    logic [RCFG_W-1:0] cfg;
    dmap_match_e       mode;
    logic              hit_lo;
    logic              hit_hi;
    logic              perm_ok;

    assign base      = rgn_addr_i[g*AW +: AW];
    assign cfg       = rgn_cfg_i[g*RCFG_W +: RCFG_W];
    assign mode      = dmap_match_e'(cfg[RCFG_MLO +: 2]);
    // Trailing ones plus the next bit form the in-region offset mask.
    assign base_inc  = base + AW'(1);
    assign span_mask = base ^ base_inc;

    always_comb begin
      unique case (mode)
        MM_EXACT: begin
          hit_lo = (lo_i == base);
          hit_hi = (hi_i == base);
        end
        MM_POW2: begin
          hit_lo = ((lo_i & ~span_mask) == (base & ~span_mask));
          hit_hi = ((hi_i & ~span_mask) == (base & ~span_mask));
        end
        default: begin
          hit_lo = 1'b0;
          hit_hi = 1'b0;
        end
      endcase
    end

    assign perm_ok   = (!need_rd_i || cfg[RCFG_RD]) && (!need_wr_i || cfg[RCFG_WR]);
    assign rgn_ok[g] = hit_lo && hit_hi && perm_ok;
  end

  assign allow_o = (|rgn_ok) && !wrap_i;

endmodule

// File: rtl/dmap_ctrl.sv
module dmap_ctrl
  import dmap_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we_i,
  input  logic [AW-1:0] ctl_src_i,
  input  logic [AW-1:0] ctl_dst_i,
  input  logic [LW-1:0] ctl_len_i,
  input  logic          src_ok_i,
  input  logic          dst_ok_i,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output dmap_state_e   state_o,
  output logic          cap_en_o,
  output logic [AW-1:0] src_lo_o,
  output logic [AW-1:0] src_hi_o,
  output logic          src_wrap_o,
  output logic [AW-1:0] dst_lo_o,
  output logic [AW-1:0] dst_hi_o,
  output logic          dst_wrap_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fault_o
);

  localparam int EW = AW + 1;

  dmap_state_e   state_q, state_d;
  logic [AW-1:0] src_q, dst_q;
  logic [LW-1:0] cnt_q;
  logic [DW-1:0] data_q;
  logic          wr_phase_q;

  logic          req_ld;
  logic          rd_go;
  logic          wr_go;
  logic [EW-1:0] src_end_x;
  logic [EW-1:0] dst_end_x;

  assign req_ld = (state_q == ST_IDLE) && ctl_we_i;
  assign rd_go  = (state_q == ST_XFER) && !wr_phase_q && mem_ready_i;
  assign wr_go  = (state_q == ST_XFER) &&  wr_phase_q && mem_ready_i;

  // Capture of region settings is allowed only at request start or acknowledge of done.
  assign cap_en_o = ctl_we_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));

  // Last address of each span, with the carry flagging wrap-around.
  assign src_end_x = EW'(src_q) + EW'(cnt_q) - EW'(1);
  assign dst_end_x = EW'(dst_q) + EW'(cnt_q) - EW'(1);

  assign src_lo_o   = src_q;
  assign src_hi_o   = src_end_x[AW-1:0];
  assign src_wrap_o = src_end_x[AW];
  assign dst_lo_o   = dst_q;
  assign dst_hi_o   = dst_end_x[AW-1:0];
  assign dst_wrap_o = dst_end_x[AW];

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ctl_we_i) state_d = ST_LOAD;
      end
      ST_LOAD: begin
        if (cnt_q == '0)               state_d = ST_DONE;
        else if (src_ok_i && dst_ok_i) state_d = ST_XFER;
        else                           state_d = ST_ABORT;
      end
      ST_XFER: begin
        if (wr_go && (cnt_q == LW'(1))) state_d = ST_DONE;
      end
      ST_DONE, ST_ABORT: begin
        if (ctl_we_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Address and count registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (req_ld) begin
      src_q <= ctl_src_i;
      dst_q <= ctl_dst_i;
      cnt_q <= ctl_len_i;
    end else if (wr_go) begin
      src_q <= src_q + AW'(1);
      dst_q <= dst_q + AW'(1);
      cnt_q <= cnt_q - LW'(1);
    end
  end

  // Data holding register and read/write phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q     <= '0;
      wr_phase_q <= 1'b0;
    end else begin
      if (rd_go) data_q <= mem_rdata_i;
      if (req_ld || wr_go) wr_phase_q <= 1'b0;
      else if (rd_go)      wr_phase_q <= 1'b1;
    end
  end

  assign state_o     = state_q;
  assign mem_req_o   = (state_q == ST_XFER);
  assign mem_we_o    = mem_req_o && wr_phase_q;
  assign mem_addr_o  = wr_phase_q ? dst_q : src_q;
  assign mem_wdata_o = data_q;
  assign busy_o      = (state_q == ST_LOAD) || (state_q == ST_XFER);
  assign done_o      = (state_q == ST_DONE);
  assign fault_o     = (state_q == ST_ABORT);

endmodule

// File: rtl/dmap_top.sv
module dmap_top
  import dmap_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int LW   = 8,
  parameter int NRGN = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_we_i,
  input  logic [AW-1:0]          ctl_src_i,
  input  logic [AW-1:0]          ctl_dst_i,
  input  logic [LW-1:0]          ctl_len_i,
  input  logic [NRGN*AW-1:0]     prot_addr_i,
  input  logic [NRGN*RCFG_W-1:0] prot_cfg_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [DW-1:0]          mem_wdata_o,
  input  logic [DW-1:0]          mem_rdata_i,
  input  logic                   mem_ready_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   fault_o
);

  dmap_state_e             st;
  logic                    cap_en;
  logic [NRGN*AW-1:0]      snap_addr;
  logic [NRGN*RCFG_W-1:0]  snap_cfg;
  logic [AW-1:0]           src_lo, src_hi, dst_lo, dst_hi;
  logic                    src_wrap, dst_wrap;
  logic                    src_ok, dst_ok;

  dmap_prot_regs #(.AW(AW), .NRGN(NRGN)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .addr_i (prot_addr_i),
    .cfg_i  (prot_cfg_i),
    .addr_q (snap_addr),
    .cfg_q  (snap_cfg)
  );

  // Source span must be readable
  dmap_prot_check #(.AW(AW), .NRGN(NRGN)) u_chk_src (
    .lo_i       (src_lo),
    .hi_i       (src_hi),
    .wrap_i     (src_wrap),
    .need_rd_i  (1'b1),
    .need_wr_i  (1'b0),
    .rgn_addr_i (snap_addr),
    .rgn_cfg_i  (snap_cfg),
    .allow_o    (src_ok)
  );

  // Destination span must be writable
  dmap_prot_check #(.AW(AW), .NRGN(NRGN)) u_chk_dst (
    .lo_i       (dst_lo),
    .hi_i       (dst_hi),
    .wrap_i     (dst_wrap),
    .need_rd_i  (1'b0),
    .need_wr_i  (1'b1),
    .rgn_addr_i (snap_addr),
    .rgn_cfg_i  (snap_cfg),
    .allow_o    (dst_ok)
  );

  dmap_ctrl #(.AW(AW), .DW(DW), .LW(LW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we_i    (ctl_we_i),
    .ctl_src_i   (ctl_src_i),
    .ctl_dst_i   (ctl_dst_i),
    .ctl_len_i   (ctl_len_i),
    .src_ok_i    (src_ok),
    .dst_ok_i    (dst_ok),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .state_o     (st),
    .cap_en_o    (cap_en),
    .src_lo_o    (src_lo),
    .src_hi_o    (src_hi),
    .src_wrap_o  (src_wrap),
    .dst_lo_o    (dst_lo),
    .dst_hi_o    (dst_hi),
    .dst_wrap_o  (dst_wrap),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fault_o     (fault_o)
  );

endmodule

// File: rtl/dmap_chk.sv
module dmap_chk
  import dmap_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int NRGN = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input dmap_state_e            st,
  input logic [NRGN*AW-1:0]     snap_addr,
  input logic [NRGN*RCFG_W-1:0] snap_cfg,
  input logic                   ctl_we_i,
  input logic                   mem_req_o,
  input logic                   mem_we_o,
  input logic [AW-1:0]          mem_addr_o,
  input logic [DW-1:0]          mem_wdata_o,
  input logic                   mem_ready_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   fault_o
);

  // R6
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(snap_addr) && $stable(snap_cfg)));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R5
  fault_after_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> ($past(st) == ST_LOAD));

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ctl_we_i) |=> done_o);

  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !ctl_we_i) |=> fault_o);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && ctl_we_i) |=> busy_o);

  // R1
  single_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, done_o, fault_o}));

endmodule

bind dmap_top dmap_chk #(.AW(AW), .DW(DW), .NRGN(NRGN)) u_dmap_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st          (st),
  .snap_addr   (snap_addr),
  .snap_cfg    (snap_cfg),
  .ctl_we_i    (ctl_we_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fault_o     (fault_o)
);

// File: tb/dmap_top_tb_top.sv
module dmap_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int LW = 8;
  localparam int NRGN = 2;
  localparam logic [15:0] RD_SALT = 16'hA5A5;

  // Settings encodings: {mode[1:0], ex, wr, rd}
  localparam logic [4:0] C_OFF    = 5'b00000;
  localparam logic [4:0] C_P2_R   = 5'b10001;
  localparam logic [4:0] C_P2_W   = 5'b10010;
  localparam logic [4:0] C_P2_RW  = 5'b10011;
  localparam logic [4:0] C_EX_R   = 5'b01001;
  localparam logic [4:0] C_EX_W   = 5'b01010;
  localparam logic [4:0] C_RSV_RW = 5'b11011;

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_we;
  logic [AW-1:0] ctl_src, ctl_dst;
  logic [LW-1:0] ctl_len;
  logic [NRGN*AW-1:0] prot_addr;
  logic [NRGN*5-1:0] prot_cfg;
  logic mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic busy, done, fault;

  logic stall_mode;
  logic tog = 1'b0;

  int checks = 0;
  int errors = 0;
  int accesses = 0;

  typedef struct packed { logic [15:0] a; logic [15:0] d; } item_t;
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tog <= ~tog;

  assign mem_ready = stall_mode ? tog : 1'b1;
  assign mem_rdata = mem_addr ^ RD_SALT;

  dmap_top #(.AW(AW), .DW(DW), .LW(LW), .NRGN(NRGN)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we_i    (ctl_we),
    .ctl_src_i   (ctl_src),
    .ctl_dst_i   (ctl_dst),
    .ctl_len_i   (ctl_len),
    .prot_addr_i (prot_addr),
    .prot_cfg_i  (prot_cfg),
    .mem_req_o   (mem_req),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_ready_i (mem_ready),
    .busy_o      (busy),
    .done_o      (done),
    .fault_o     (fault)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  // Monitor: pops expected writes, watches stalls (R8, R9)
  logic          prev_stall = 1'b0;
  logic [AW-1:0] prev_addr;
  logic          prev_we;
  logic [DW-1:0] prev_wdata;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wdata,
            "R9", "stalled access held", int'(mem_addr), int'(prev_addr));
      end
      prev_stall = mem_req && !mem_ready;
      prev_addr  = mem_addr;
      prev_we    = mem_we;
      prev_wdata = mem_wdata;
      if (mem_req && mem_ready) begin
        accesses++;
        if (mem_we) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8", "unexpected write addr", int'(mem_addr), 0);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            chk(mem_addr == it.a, "R8", "write address", int'(mem_addr), int'(it.a));
            chk(mem_wdata == it.d, "R8", "write data", int'(mem_wdata), int'(it.d));
          end
        end
      end
    end
  end

  task automatic set_rgn(input int idx, input logic [15:0] a, input logic [4:0] c);
    prot_addr[idx*AW +: AW] = a;
    prot_cfg[idx*5 +: 5]    = c;
  endtask

  // Driver: pushes expected writes, then issues the control write.
  task automatic start(input logic [15:0] s, input logic [15:0] d,
                       input int len, input bit expect_ok);
    if (expect_ok) begin
      for (int i = 0; i < len; i++) begin
        item_t it;
        it.a = d + 16'(i);
        it.d = (s + 16'(i)) ^ RD_SALT;
        exp_q.push_back(it);
      end
    end
    accesses = 0;
    @(negedge clk);
    ctl_src = s; ctl_dst = d; ctl_len = LW'(len); ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wait_end(input string rq, input bit expect_ok);
    int n = 0;
    while (!done && !fault && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(done == expect_ok && fault == !expect_ok, rq, "end status {done,fault}",
        int'({done, fault}), int'({expect_ok, !expect_ok}));
    chk(exp_q.size() == 0, rq, "pending expected writes", exp_q.size(), 0);
    if (!expect_ok) chk(accesses == 0, rq, "accesses on fault", accesses, 0);
    exp_q.delete();
  endtask

  task automatic ack(input string rq);
    @(negedge clk);
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    chk(!busy && !done && !fault, rq, "idle after acknowledge",
        int'({busy, done, fault}), 0);
  endtask

  task automatic run(input logic [15:0] s, input logic [15:0] d, input int len,
                     input bit expect_ok, input string rq);
    start(s, d, len, expect_ok);
    wait_end(rq, expect_ok);
    ack(rq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_src = '0; ctl_dst = '0; ctl_len = '0;
    prot_addr = '0; prot_cfg = '0; stall_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !fault && !mem_req, "R1", "reset outputs",
        int'({busy, done, fault, mem_req}), 0);

    // R2 R4 R8: aligned regions 0x2000-0x200F readable, 0x3000-0x300F writable
    set_rgn(0, 16'h2007, C_P2_R);
    set_rgn(1, 16'h3007, C_P2_W);
    start(16'h2002, 16'h3004, 4, 1'b1);
    chk(busy, "R2", "busy after start", int'(busy), 1);
    wait_end("R8", 1'b1);
    ack("R11");

    // R9: stalls, span ends exactly at region top
    stall_mode = 1'b1;
    run(16'h2008, 16'h3008, 8, 1'b1, "R9");
    stall_mode = 1'b0;

    // R4 R5: source span leaves the region
    run(16'h200C, 16'h3000, 8, 1'b0, "R4");

    // R5: destination region only readable
    set_rgn(1, 16'h3007, C_P2_R);
    run(16'h2000, 16'h3000, 2, 1'b0, "R5");
    // R5: source region only writable
    set_rgn(0, 16'h2007, C_P2_W);
    set_rgn(1, 16'h3007, C_P2_W);
    run(16'h2000, 16'h3000, 2, 1'b0, "R5");

    // R6: region widened to a privileged address after start
    set_rgn(0, 16'h2007, C_P2_R);
    start(16'h8000, 16'h3000, 2, 1'b0);
    set_rgn(0, 16'h8007, C_P2_R);
    wait_end("R6", 1'b0);
    ack("R6");

    // R6: region removed after start, copy still completes
    set_rgn(0, 16'h2007, C_P2_R);
    stall_mode = 1'b1;
    start(16'h2000, 16'h3000, 6, 1'b1);
    set_rgn(0, 16'h0000, C_OFF);
    set_rgn(1, 16'h0000, C_OFF);
    wait_end("R6", 1'b1);
    ack("R6");
    stall_mode = 1'b0;

    // R7: every region off
    run(16'h2000, 16'h3000, 1, 1'b0, "R7");

    // R3: reserved mode acts as off
    set_rgn(0, 16'h7FFF, C_RSV_RW);
    set_rgn(1, 16'h7FFF, C_RSV_RW);
    run(16'h2000, 16'h3000, 1, 1'b0, "R3");

    // R3: exact mode passes a single word, fails two
    set_rgn(0, 16'h2000, C_EX_R);
    set_rgn(1, 16'h3000, C_EX_W);
    run(16'h2000, 16'h3000, 1, 1'b1, "R3");
    run(16'h2000, 16'h3000, 2, 1'b0, "R3");

    // R10: zero length with all regions off
    set_rgn(0, 16'h0000, C_OFF);
    set_rgn(1, 16'h0000, C_OFF);
    start(16'h2000, 16'h3000, 0, 1'b1);
    wait_end("R10", 1'b1);
    chk(accesses == 0, "R10", "accesses for zero length", accesses, 0);
    ack("R10");

    // R11: control write during copy ignored, done held
    set_rgn(0, 16'h2007, C_P2_R);
    set_rgn(1, 16'h3007, C_P2_W);
    stall_mode = 1'b1;
    start(16'h2004, 16'h3002, 4, 1'b1);
    @(negedge clk);
    ctl_src = 16'h9000; ctl_dst = 16'h9100; ctl_len = 8'd1; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    chk(busy, "R11", "busy after ignored write", int'(busy), 1);
    wait_end("R11", 1'b1);
    repeat (3) @(negedge clk);
    chk(done && !busy, "R11", "done held", int'({done, busy}), 2);
    ack("R11");
    stall_mode = 1'b0;

    // R12: wrap past the top fails; span ending at the top passes
    set_rgn(0, 16'h7FFF, C_P2_RW);
    set_rgn(1, 16'h7FFF, C_P2_RW);
    run(16'hFFFE, 16'h1000, 4, 1'b0, "R12");
    run(16'hFFFC, 16'h1000, 4, 1'b1, "R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule